// File: doc/BRIEF.md
# Left-Justified to I2S Serial Audio Retimer

This block accepts a serial audio stream framed in left-justified form: a bit clock, a word select and one serial data line. The source that produces the stream runs from the same low-jitter master clock as this block, so all three inputs are synchronous to that clock. The block resamples every input on the master clock. It then delays the data by exactly one bit-clock period, so the first bit of each word appears one bit clock after the word-select transition, as I2S framing requires.

The one-bit delay is built from two captures:

- The first capture takes the data on the rising edge of the retimed bit clock.
- The second capture takes the first one's result on the falling edge of the retimed bit clock.
- A final master-clock register drives the data output.

The bit clock and the word select pass through register stages of the same depth. All three outputs therefore change on the same master-clock edge, and the downstream converter sees the delayed data in the same phase relationship to the clocks that the undelayed data had.

A parameter sets the word-select polarity at the output. Left-justified streams mark the left channel with word select high, while I2S marks it with word select low. The block is meant for a master clock of 256 times the sample rate, for example 11.2896 MHz at 44.1 kHz. It works at any master-clock to bit-clock ratio of 4 or more.

Top module: `lj2i2s_reclock`

## Requirements
- R1: While `rst` is high at a clock edge, every output is 0 after that edge, whatever the inputs are.
- R2: `bck_out` equals `bck_in` delayed by SYNC_STAGES+2 master-clock edges (3 with defaults), and every input bit-clock rising edge produces exactly one output rising edge.
- R3: With WS_INVERT=1 (default), `ws_out` equals the inverse of `ws_in` delayed by the same SYNC_STAGES+2 edges as the bit clock.
- R4: On each output bit-clock rising edge, `sd_out` holds the data bit that was present at the input bit-clock rising edge one bit-clock period earlier.
- R5: `sd_out` changes only on a master-clock edge at which `bck_out` falls from 1 to 0.
- R6: On the first output bit-clock rising edge after a `ws_out` transition, `sd_out` carries the last bit (LSB) of the previous word. The new word's first bit (MSB) follows one bit clock later.
- R7: With WS_INVERT=0, `ws_out` equals `ws_in` delayed by SYNC_STAGES+2 edges, without inversion.
- R8: Data is taken only at input bit-clock rising edges. A change on `sd_in` that arrives one master cycle or more after the bit clock rose, and before the next falling edge, does not reach `sd_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, shared with the upstream source |
| rst | input | 1 | Synchronous active-high reset |
| bck_in | input | 1 | Left-justified bit clock, synchronous to clk |
| ws_in | input | 1 | Left-justified word select (high = left channel) |
| sd_in | input | 1 | Left-justified serial data, MSB first |
| bck_out | output | 1 | Retimed bit clock |
| ws_out | output | 1 | Retimed word select, polarity set by WS_INVERT |
| sd_out | output | 1 | Retimed serial data, one bit clock later than input |

## Verification
The output word-select transition and the data-delay update fall on the same master-clock edge, the one on which the retimed bit clock falls. Each frame half starts by changing the word select together with the bit-clock fall, which provokes this case on every channel boundary. It is judged at the next output rising edge: the data there must still be the previous word's LSB, and the new MSB must come one bit clock later. The bench also toggles the data input while the bit clock is high, so that the rising-edge capture and a data change fall in adjacent cycles. The bit sent before the toggle must still reach the output.

// File: rtl/lj2i2s_pkg.sv
package lj2i2s_pkg;

  // One sample of the three serial-audio wires.
  typedef struct packed {
    logic bck;
    logic ws;
    logic sd;
  } ser_bus_t;

  // Register stages after input sampling: one align stage and one output stage.
  localparam int unsigned POST_STAGES = 2;

endpackage

// File: rtl/lj2i2s_sampler.sv
module lj2i2s_sampler
  import lj2i2s_pkg::*;
#(
  parameter int unsigned STAGES = 1
) (
  input  logic     clk,
  input  logic     rst,
  input  ser_bus_t din,
  output ser_bus_t dout
);

  ser_bus_t pipe [STAGES];

  // The same number of master-clock stages for all three wires.
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= '0;
        else     pipe[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= '0;
        else     pipe[g] <= pipe[g-1];
      end
    end
  end

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/lj2i2s_edge.sv
module lj2i2s_edge (
  input  logic clk,
  input  logic rst,
  input  logic bck,
  output logic rise,
  output logic fall
);

  logic bck_prev;

  always_ff @(posedge clk) begin
    if (rst) bck_prev <= 1'b0;
    else     bck_prev <= bck;
  end

  assign rise = bck & ~bck_prev;
  assign fall = ~bck & bck_prev;

  // A rising strobe lasts one master cycle.
  assert_rise_single_cycle_R8: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);

endmodule

// File: rtl/lj2i2s_delay.sv
module lj2i2s_delay (
  input  logic clk,
  input  logic rst,
  input  logic sd,
  input  logic rise,
  input  logic fall,
  output logic sd_late
);

  logic cap_rise;
  logic cap_fall;

  // First capture: on the rising edge of the retimed bit clock.
  always_ff @(posedge clk) begin
    if (rst)       cap_rise <= 1'b0;
    else if (rise) cap_rise <= sd;
  end

  // Second capture: on the falling edge of the retimed bit clock.
  always_ff @(posedge clk) begin
    if (rst)       cap_fall <= 1'b0;
    else if (fall) cap_fall <= cap_rise;
  end

  assign sd_late = cap_fall;

  // The first capture moves only after a rising strobe.
  assert_capture_on_rise_R8: assert property (@(posedge clk) disable iff (rst)
    (cap_rise != $past(cap_rise)) |-> $past(rise));

  // The delayed bit moves only after a falling strobe.
  assert_delay_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
    (cap_fall != $past(cap_fall)) |-> $past(fall));

endmodule

// File: rtl/lj2i2s_outstage.sv
module lj2i2s_outstage #(
  parameter bit WS_INVERT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic bck,
  input  logic ws,
  input  logic sd_late,
  output logic bck_o,
  output logic ws_o,
  output logic sd_o
);

  logic bck_align;
  logic ws_align;

  // Align stage: matches the latency of the data-capture register.
  always_ff @(posedge clk) begin
    if (rst) begin
      bck_align <= 1'b0;
      ws_align  <= 1'b0;
    end else begin
      bck_align <= bck;
      ws_align  <= ws;
    end
  end

  // Output stage: the three outputs leave from registers on the same edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      bck_o <= 1'b0;
      ws_o  <= 1'b0;
      sd_o  <= 1'b0;
    end else begin
      bck_o <= bck_align;
      ws_o  <= ws_align ^ WS_INVERT;
      sd_o  <= sd_late;
    end
  end

endmodule

// File: rtl/lj2i2s_reclock.sv
module lj2i2s_reclock
  import lj2i2s_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 1,
  parameter bit          WS_INVERT   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic bck_in,
  input  logic ws_in,
  input  logic sd_in,
  output logic bck_out,
  output logic ws_out,
  output logic sd_out
);

  localparam int unsigned LATENCY = SYNC_STAGES + POST_STAGES;

  ser_bus_t raw;
  ser_bus_t smp;
  logic     bck_rise;
  logic     bck_fall;
  logic     sd_late;

  assign raw = '{bck: bck_in, ws: ws_in, sd: sd_in};

  lj2i2s_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
    .clk  (clk),
    .rst  (rst),
    .din  (raw),
    .dout (smp)
  );

  lj2i2s_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .bck  (smp.bck),
    .rise (bck_rise),
    .fall (bck_fall)
  );

  lj2i2s_delay u_delay (
    .clk     (clk),
    .rst     (rst),
    .sd      (smp.sd),
    .rise    (bck_rise),
    .fall    (bck_fall),
    .sd_late (sd_late)
  );

  lj2i2s_outstage #(.WS_INVERT(WS_INVERT)) u_out (
    .clk     (clk),
    .rst     (rst),
    .bck     (smp.bck),
    .ws      (smp.ws),
    .sd_late (sd_late),
    .bck_o   (bck_out),
    .ws_o    (ws_out),
    .sd_o    (sd_out)
  );

  initial begin
    assert_latency_valid_R2: assert (LATENCY >= 3);
  end

  // The cycle after reset, all outputs are low.
  assert_reset_low_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!bck_out && !ws_out && !sd_out));

  // Data at the output moves only together with a bit-clock fall.
  assert_sd_moves_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
    (sd_out != $past(sd_out)) |-> (!bck_out && $past(bck_out)));

endmodule

// File: tb/lj2i2s_reclock_test.sv
module lj2i2s_reclock_test;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_SLOTS  = 2048;
  localparam int WATCHDOG   = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bck_in = 1'b0, ws_in = 1'b0, sd_in = 1'b0;
  logic bck_out, ws_out, sd_out;
  logic bck_pass, ws_pass, sd_pass;

  always #(CLK_PERIOD/2) clk = ~clk;

  lj2i2s_reclock uut (
    .clk(clk), .rst(rst), .bck_in(bck_in), .ws_in(ws_in), .sd_in(sd_in),
    .bck_out(bck_out), .ws_out(ws_out), .sd_out(sd_out)
  );

  lj2i2s_reclock #(.WS_INVERT(1'b0)) uut_pass (
    .clk(clk), .rst(rst), .bck_in(bck_in), .ws_in(ws_in), .sd_in(sd_in),
    .bck_out(bck_pass), .ws_out(ws_pass), .sd_out(sd_pass)
  );

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 1'b0;
  logic slot_sd [MAX_SLOTS];
  int  n_slots  = 0;
  bit  glitch   = 1'b0;
  bit  chk_on   = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Input history sampled at the active edge; [2] is three edges old.
  logic [2:0] h_bck = '0, h_ws = '0;
  always @(posedge clk) begin
    h_bck <= {h_bck[1:0], bck_in};
    h_ws  <= {h_ws[1:0], ws_in};
  end

  // Output monitor, sampled away from the active edge.
  logic prev_bck = 1'b0, prev_sd = 1'b0, last_rise_ws = 1'b0;
  int   rise_n = 0;
  always @(negedge clk) begin
    if (chk_on) begin
      check(bck_out == h_bck[2], "R2", "bck latency", bck_out, h_bck[2]);
      check(ws_out == ~h_ws[2], "R3", "ws inverted", ws_out, ~h_ws[2]);
      check(ws_pass == h_ws[2], "R7", "ws pass-through", ws_pass, h_ws[2]);
      if (sd_out != prev_sd)
        check(!bck_out && prev_bck, "R5", "sd moved without bck fall",
              {bck_out, prev_bck}, 2'b01);
      if (bck_out && !prev_bck) begin
        if (rise_n >= 1 && rise_n - 1 < n_slots) begin
          if (ws_out != last_rise_ws)
            check(sd_out == slot_sd[rise_n-1], "R6", "LSB after ws edge",
                  sd_out, slot_sd[rise_n-1]);
          else
            check(sd_out == slot_sd[rise_n-1], "R4", "one-bit delay",
                  sd_out, slot_sd[rise_n-1]);
        end
        last_rise_ws = ws_out;
        rise_n++;
      end
    end
    prev_bck = bck_out;
    prev_sd  = sd_out;
  end

  task automatic send_slot(input logic ws, input logic b);
    @(negedge clk);
    bck_in = 1'b0; ws_in = ws; sd_in = b;
    slot_sd[n_slots] = b;
    n_slots++;
    @(negedge clk);
    @(negedge clk);
    bck_in = 1'b1;
    @(negedge clk);
    if (glitch) sd_in = ~b;
  endtask

  task automatic send_frame(input logic [31:0] left, input logic [31:0] right);
    for (int i = 0; i < 32; i++) send_slot(1'b1, left[31-i]);
    for (int i = 0; i < 32; i++) send_slot(1'b0, right[31-i]);
  endtask

  task automatic test_reset();
    rst = 1'b1; bck_in = 1'b1; ws_in = 1'b1; sd_in = 1'b1;
    repeat (5) @(negedge clk);
    check({bck_out, ws_out, sd_out} == 3'b000, "R1", "outputs in reset",
          {bck_out, ws_out, sd_out}, 3'b000);
    check({bck_pass, ws_pass, sd_pass} == 3'b000, "R1", "pass outputs in reset",
          {bck_pass, ws_pass, sd_pass}, 3'b000);
    bck_in = 1'b0; ws_in = 1'b0; sd_in = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk_on = 1'b1;
  endtask

  task automatic test_patterns();
    int f0 = n_fail;
    send_frame(32'hAAAA_AAAA, 32'h5555_5555);
    send_frame(32'h1234_5678, 32'h9ABC_DEF0);
    send_frame(32'hFFFF_FFFF, 32'h0000_0000);
    send_frame(32'hC3A5_0F96, 32'h6B1E_D247);
    if (n_fail != f0) $display("  patterns: %0d new failures", n_fail - f0);
  endtask

  task automatic test_word_edges();
    int f0 = n_fail;
    // LSB differs from the next MSB at every channel boundary.
    send_frame(32'h8000_0001, 32'h7FFF_FFFE);
    send_frame(32'h0000_0001, 32'hFFFF_FFFE);
    send_frame(32'hFFFF_FFFE, 32'h0000_0001);
    if (n_fail != f0) $display("  word edges: %0d new failures", n_fail - f0);
  endtask

  task automatic test_glitch();
    int f0 = n_fail;
    glitch = 1'b1;  // R8: data toggled while bit clock is high
    send_frame(32'hF0F0_0F0F, 32'h3CC3_A55A);
    send_frame(32'h0000_0000, 32'hFFFF_FFFF);
    glitch = 1'b0;
    if (n_fail != f0) $display("  glitch: %0d new failures", n_fail - f0);
  endtask

  task automatic test_tail();
    send_frame(32'h0, 32'h0);
    repeat (12) @(negedge clk);
    check(rise_n == n_slots, "R2", "one output rise per input rise", rise_n, n_slots);
  endtask

  initial begin
    test_reset();
    test_patterns();
    test_word_edges();
    test_glitch();
    test_tail();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule